// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes a destination operand, a second operand, an operation code and the current carry. The second operand is either a register value or an immediate. It produces an 8-bit result at once, with no register on the path, together with a flag that says whether the result should be written back to the register file. The carry it uses is the C bit held in its own status register.

The block keeps an 8-bit status register. From bit 7 down to bit 0 it holds I, T, H, S, V, N, Z, C. When `valid_i` is high, the register takes the flags of the current operation on the rising clock edge. Each class of operation writes only its own group of flags, and every other bit keeps its value. Two dedicated operations set or clear any single status bit, chosen by index.

Top module: `alu8_status`

## Requirements
- R1: While `rst_n` is low, `sreg_o` is cleared to 0x00 without waiting for a clock edge.
- R2: Add (op 0) and add-with-carry (op 1, which also adds C) return `rd + b (+C)` modulo 256 and write Z, N, V, H and C. H is the carry out of bit 3, C is the carry out of bit 7, and V is the signed overflow.
- R3: Subtract (op 2) and subtract-with-carry (op 3, which also subtracts C) return `rd - b (-C)` modulo 256 and write Z, N, V, H and C. H is the borrow out of bit 3, C is the borrow out of bit 7, and V is the signed overflow.
- R4: Compare (op 4) and compare-with-carry (op 5) write the same flags as ops 2 and 3 but hold `wr_en_o` low. Every other defined op holds `wr_en_o` high, except TST (op 9), flag set and flag clear (ops 20 and 21), and the undefined codes 22 to 31.
- R5: For ops 3 and 5, Z is set only when the result is zero and Z was already 1; a cleared Z stays cleared.
- R6: AND (op 6), OR (op 7), XOR (op 8) and TST (op 9, result `rd`) write Z and N from the result and clear V. C and H keep their values.
- R7: Increment (op 12) and decrement (op 13) write Z and N. V is set exactly when the operand is 0x7F (increment) or 0x80 (decrement). C and H keep their values.
- R8: One's complement (op 10) returns `0xFF - rd`, sets C to 1 and clears V. Two's complement (op 11) returns `0x00 - rd` and writes its flags as a subtraction from zero, including H.
- R9: Shift left (op 14) and shift right (op 15) fill the vacated bit with 0. The rotates, left (op 16) and right (op 17), fill the vacated bit with the old C. Arithmetic shift right (op 18) keeps bit 7. In all five the bit shifted out goes to C, N and Z come from the result, V = N xor C, and H keeps its value.
- R10: Nibble swap (op 19) exchanges bits 7..4 with bits 3..0 and leaves every flag unchanged.
- R11: Flag set (op 20) and flag clear (op 21) write 1 or 0 into status bit `bit_sel_i` and change no other bit. The bit order from 7 down to 0 is I, T, H, S, V, N, Z, C.
- R12: After every op from 0 to 18, S equals N xor V.
- R13: With `use_imm_i` high, `imm_i` replaces `rr_i` as the second operand.
- R14: While `valid_i` is low, the status register holds its value, and no op changes the I or T bits except ops 20 and 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Status register takes this cycle's flags |
| op_i | input | 5 | Operation code |
| rd_i | input | 8 | Destination operand |
| rr_i | input | 8 | Register second operand |
| imm_i | input | 8 | Immediate second operand |
| use_imm_i | input | 1 | Select immediate as second operand |
| bit_sel_i | input | 3 | Status bit index for flag set or clear |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Result should be written back |
| sreg_o | output | 8 | Status register I,T,H,S,V,N,Z,C |

## Verification
The adders are driven with operand pairs chosen to separate the flag causes. 0x0F+0x01 produces a nibble carry only. 0x7F+0x01 produces a signed overflow without a carry. 0x80+0x80 produces carry, overflow and a zero result together. Chains of subtract-with-carry after a nonzero byte show whether Z is sticky or simply recomputed. The shifts and rotates run with C both 0 and 1, which shows whether the fill bit comes from the old carry or is a constant. A long stream of random operands, op codes and immediate selections then checks every result against a bench model built on integer arithmetic.

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] rd_i,
  input  logic [W-1:0] rr_i,
  input  logic [W-1:0] imm_i,
  input  logic         use_imm_i,
  input  logic [2:0]   bit_sel_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [7:0]   sreg_o
);
  localparam int MSB = W - 1;
  localparam int HB  = 3;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8,  OP_TST = 5'd9,  OP_COM = 5'd10, OP_NEG = 5'd11;
  localparam logic [4:0] OP_INC = 5'd12, OP_DEC = 5'd13, OP_LSL = 5'd14, OP_LSR = 5'd15;
  localparam logic [4:0] OP_ROL = 5'd16, OP_ROR = 5'd17, OP_ASR = 5'd18, OP_SWP = 5'd19;
  localparam logic [4:0] OP_SET = 5'd20, OP_CLR = 5'd21;

  logic [7:0]   sreg, nf;
  logic [W-1:0] a, b, r, sa, sb;
  logic [W:0]   sum, dif;
  logic         c, cadd, csub, hadd, hsub, vadd, vsub;
  logic         upd_zn, upd_s, sticky, wr;

  assign a  = rd_i;
  assign b  = use_imm_i ? imm_i : rr_i;
  assign c  = sreg[FC];

  assign cadd = (op_i == OP_ADC) & c;
  assign csub = (op_i == OP_SBC || op_i == OP_CPC) & c;
  assign sa   = (op_i == OP_NEG) ? '0 : a;
  assign sb   = (op_i == OP_NEG) ? a  : b;

  assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cadd};
  assign dif = {1'b0, sa} - {1'b0, sb} - {{W{1'b0}}, csub};

  assign hadd = (a[HB] & b[HB]) | (b[HB] & ~sum[HB]) | (~sum[HB] & a[HB]);
  assign hsub = (~sa[HB] & sb[HB]) | (sb[HB] & dif[HB]) | (dif[HB] & ~sa[HB]);
  assign vadd = (a[MSB] & b[MSB] & ~sum[MSB]) | (~a[MSB] & ~b[MSB] & sum[MSB]);
  assign vsub = (sa[MSB] & ~sb[MSB] & ~dif[MSB]) | (~sa[MSB] & sb[MSB] & dif[MSB]);

  always_comb begin
    r      = a;
    nf     = sreg;
    wr     = 1'b1;
    upd_zn = 1'b1;
    upd_s  = 1'b1;
    sticky = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC: begin
        r = sum[MSB:0];
        nf[FH] = hadd; nf[FV] = vadd; nf[FC] = sum[W];
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        r = dif[MSB:0];
        nf[FH] = hsub; nf[FV] = vsub; nf[FC] = dif[W];
        sticky = (op_i == OP_SBC) || (op_i == OP_CPC);
        wr     = !(op_i == OP_CP || op_i == OP_CPC);
      end
      OP_AND: begin r = a & b; nf[FV] = 1'b0; end
      OP_OR:  begin r = a | b; nf[FV] = 1'b0; end
      OP_XOR: begin r = a ^ b; nf[FV] = 1'b0; end
      OP_TST: begin r = a;     nf[FV] = 1'b0; wr = 1'b0; end
      OP_COM: begin r = ~a; nf[FV] = 1'b0; nf[FC] = 1'b1; end
      OP_INC: begin r = a + 1'b1; nf[FV] = (a == {1'b0, {MSB{1'b1}}}); end
      OP_DEC: begin r = a - 1'b1; nf[FV] = (a == {1'b1, {MSB{1'b0}}}); end
      OP_LSL: begin r = {a[MSB-1:0], 1'b0}; nf[FC] = a[MSB]; nf[FV] = a[MSB-1] ^ a[MSB]; end
      OP_ROL: begin r = {a[MSB-1:0], c};    nf[FC] = a[MSB]; nf[FV] = a[MSB-1] ^ a[MSB]; end
      OP_LSR: begin r = {1'b0, a[MSB:1]};   nf[FC] = a[0];   nf[FV] = a[0]; end
      OP_ROR: begin r = {c, a[MSB:1]};      nf[FC] = a[0];   nf[FV] = c ^ a[0]; end
      OP_ASR: begin r = {a[MSB], a[MSB:1]}; nf[FC] = a[0];   nf[FV] = a[MSB] ^ a[0]; end
      OP_SWP: begin
        r = {a[HB:0], a[MSB:HB+1]};
        upd_zn = 1'b0; upd_s = 1'b0;
      end
      OP_SET, OP_CLR: begin
        nf[bit_sel_i] = (op_i == OP_SET);
        wr = 1'b0; upd_zn = 1'b0; upd_s = 1'b0;
      end
      default: begin wr = 1'b0; upd_zn = 1'b0; upd_s = 1'b0; end
    endcase
    if (upd_zn) begin
      nf[FN] = r[MSB];
      nf[FZ] = (r == '0) && (!sticky || sreg[FZ]);
    end
    if (upd_s) nf[FS] = nf[FN] ^ nf[FV];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg <= '0;
    else if (valid_i) sreg <= nf;
  end

  assign result_o = r;
  assign wr_en_o  = wr;
  assign sreg_o   = sreg;
endmodule

module alu8_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic [4:0] op_i,
  input logic [2:0] bit_sel_i,
  input logic       wr_en_o,
  input logic [7:0] sreg_o
);
  logic arith;
  assign arith = valid_i && (op_i <= 5'd18);

  assert_sflag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    arith |=> sreg_o[4] == (sreg_o[3] ^ sreg_o[2]));
  assert_logic_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i >= 5'd6 && op_i <= 5'd9) |=> (sreg_o[0] == $past(sreg_o[0]) && sreg_o[5] == $past(sreg_o[5]) && !sreg_o[3]));
  assert_incdec_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 5'd12 || op_i == 5'd13)) |=> (sreg_o[0] == $past(sreg_o[0]) && sreg_o[5] == $past(sreg_o[5])));
  assert_com_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 5'd10) |=> (sreg_o[0] && !sreg_o[3]));
  assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd4 || op_i == 5'd5) |-> !wr_en_o);
  assert_sticky_z_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 5'd3 || op_i == 5'd5) && !sreg_o[1]) |=> !sreg_o[1]);
  assert_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 5'd19) |=> $stable(sreg_o));
  assert_fset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 5'd20) |=> sreg_o[$past(bit_sel_i)]);
  assert_fclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 5'd21) |=> !sreg_o[$past(bit_sel_i)]);
  assert_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(sreg_o));
  assert_it_keep_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 5'd20 && op_i != 5'd21) |=> sreg_o[7:6] == $past(sreg_o[7:6]));
endmodule

bind alu8_status alu8_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
  .bit_sel_i(bit_sel_i), .wr_en_o(wr_en_o), .sreg_o(sreg_o)
);

// File: tb/sim_alu8_status.sv
module sim_alu8_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] rd_i = '0, rr_i = '0, imm_i = '0;
  logic       use_imm_i = 1'b0;
  logic [2:0] bit_sel_i = '0;
  logic [7:0] result_o, sreg_o;
  logic       wr_en_o;

  int checks = 0, fails = 0;
  logic [7:0] m_sreg = '0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [7:0] res;
    logic       wr;
    logic [7:0] sr;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  alu8_status u0 (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input int op, input logic [7:0] a, input logic [7:0] b,
                                input logic [2:0] bs, input logic [7:0] f,
                                output logic [7:0] r, output logic w, output logic [7:0] nf);
    int ai, bi, ci, x, sx, lo;
    bit zn, s, stick;
    ai = a; bi = b; ci = f[0];
    nf = f; r = a; w = 1; zn = 1; s = 1; stick = 0;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        x = ai + bi + ci; r = x[7:0];
        nf[0] = x > 255;
        nf[5] = ((ai % 16) + (bi % 16) + ci) > 15;
        sx = int'($signed(a)) + int'($signed(b)) + ci;
        nf[3] = (sx > 127) || (sx < -128);
      end
      2, 3, 4, 5, 11: begin
        if (op == 2 || op == 4 || op == 11) ci = 0;
        if (op == 11) begin bi = ai; ai = 0; end
        x = ai - bi - ci; r = x[7:0];
        nf[0] = x < 0;
        lo = (ai % 16) - (bi % 16) - ci;
        nf[5] = lo < 0;
        sx = (ai > 127 ? ai - 256 : ai) - (bi > 127 ? bi - 256 : bi) - ci;
        nf[3] = (sx > 127) || (sx < -128);
        stick = (op == 3 || op == 5);
        w = !(op == 4 || op == 5);
      end
      6:  begin r = a & b; nf[3] = 0; end
      7:  begin r = a | b; nf[3] = 0; end
      8:  begin r = a ^ b; nf[3] = 0; end
      9:  begin r = a; nf[3] = 0; w = 0; end
      10: begin r = 8'(255 - ai); nf[0] = 1; nf[3] = 0; end
      12: begin r = 8'(ai + 1); nf[3] = (ai == 127); end
      13: begin r = 8'(ai - 1); nf[3] = (ai == 128); end
      14, 15, 16, 17, 18: begin
        case (op)
          14: begin r = 8'(ai * 2);             nf[0] = ai >= 128; end
          16: begin r = 8'(ai * 2 + ci);        nf[0] = ai >= 128; end
          15: begin r = 8'(ai / 2);             nf[0] = ai % 2; end
          17: begin r = 8'(ai / 2 + ci * 128);  nf[0] = ai % 2; end
          default: begin r = 8'(ai / 2 + (ai >= 128 ? 128 : 0)); nf[0] = ai % 2; end
        endcase
        nf[3] = r[7] ^ nf[0];
      end
      19: begin r = 8'((ai % 16) * 16 + ai / 16); zn = 0; s = 0; end
      20, 21: begin nf[bs] = (op == 20); w = 0; zn = 0; s = 0; end
      default: begin w = 0; zn = 0; s = 0; end
    endcase
    if (zn) begin
      nf[2] = r[7];
      nf[1] = (r == 0) && (!stick || f[1]);
    end
    if (s) nf[4] = nf[2] ^ nf[3];
  endfunction

  task automatic drive(input string tag, input int op, input logic [7:0] a, input logic [7:0] b,
                       input bit imm = 0, input logic [2:0] bs = 0, input bit v = 1);
    item_t it;
    logic [7:0] r, nf;
    logic w;
    @(negedge clk);
    valid_i = v; op_i = 5'(op); rd_i = a; use_imm_i = imm; bit_sel_i = bs;
    if (imm) begin imm_i = b; rr_i = ~b; end
    else     begin rr_i = b;  imm_i = ~b; end
    model(op, a, b, bs, m_sreg, r, w, nf);
    it.tag = tag; it.res = r; it.wr = w; it.sr = v ? nf : m_sreg;
    if (v) m_sreg = nf;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.tag, "result", result_o, it.res);
        check(it.tag, "wr_en", wr_en_o, it.wr);
        @(posedge clk); #1;
        check(it.tag, "sreg", sreg_o, it.sr);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 check("R1", "reset sreg", sreg_o, 0);
    @(negedge clk) rst_n = 1'b1;

    drive("R2", 0, 8'h0F, 8'h01);
    drive("R2", 0, 8'h7F, 8'h01);
    drive("R2", 0, 8'h80, 8'h80);
    drive("R2", 1, 8'h10, 8'h20);
    drive("R3", 2, 8'h10, 8'h01);
    drive("R3", 2, 8'h80, 8'h01);
    drive("R3", 2, 8'h00, 8'h01);
    drive("R3", 3, 8'h05, 8'h04);
    drive("R4", 4, 8'h33, 8'h33);
    drive("R4", 5, 8'h33, 8'h40);
    drive("R5", 2, 8'h01, 8'h01);
    drive("R5", 3, 8'h00, 8'h00);
    drive("R5", 2, 8'h01, 8'h00);
    drive("R5", 3, 8'h00, 8'h00);
    drive("R5", 5, 8'h20, 8'h20);
    drive("R13", 0, 8'h11, 8'h22, 1);
    drive("R13", 6, 8'hF0, 8'h3C, 1);
    drive("R0C", 20, 0, 0, 0, 3'd0);
    drive("R0C", 20, 0, 0, 0, 3'd5);
    drive("R6", 6, 8'hAA, 8'h55);
    drive("R6", 7, 8'h80, 8'h01);
    drive("R6", 8, 8'hFF, 8'h0F);
    drive("R6", 9, 8'h00, 8'h00);
    drive("R7", 12, 8'h7F, 0);
    drive("R7", 12, 8'hFF, 0);
    drive("R7", 13, 8'h80, 0);
    drive("R7", 13, 8'h01, 0);
    drive("R8", 10, 8'h5A, 0);
    drive("R8", 11, 8'h00, 0);
    drive("R8", 11, 8'h80, 0);
    drive("R8", 11, 8'h01, 0);
    for (int cb = 0; cb < 2; cb++) begin
      drive("R9", cb ? 20 : 21, 0, 0, 0, 3'd0);
      drive("R9", 16, 8'h81, 0);
      drive("R9", cb ? 20 : 21, 0, 0, 0, 3'd0);
      drive("R9", 17, 8'h81, 0);
      drive("R9", 14, 8'hC3, 0);
      drive("R9", 15, 8'h81, 0);
      drive("R9", 18, 8'h81, 0);
      drive("R9", 18, 8'h40, 0);
    end
    drive("R10", 19, 8'h3C, 0);
    drive("R10", 19, 8'hA5, 0);
    for (int i = 0; i < 8; i++) drive("R11", 20, 0, 0, 0, 3'(i));
    for (int i = 7; i >= 0; i -= 2) drive("R11", 21, 0, 0, 0, 3'(i));
    drive("R12", 0, 8'h7F, 8'h7F);
    drive("R12", 2, 8'h80, 8'h7F);
    drive("R14", 0, 8'hFF, 8'hFF, 0, 0, 0);
    drive("R14", 21, 0, 0, 0, 3'd6, 0);
    for (int n = 0; n < 400; n++)
      drive("R12", int'($urandom_range(0, 25)), 8'($urandom), 8'($urandom),
            1'($urandom), 3'($urandom), ($urandom_range(0, 7) != 0));
    @(negedge clk); valid_i = 1'b0;
    repeat (4) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule